// File: doc/BRIEF.md
# 16-bit DSP Execution Core (Instruction Subset)

This block is a compact execution core for a 16-bit digital signal processor whose instruction and data spaces are addressed in 16-bit words. Each cycle it presents the program counter on an instruction memory port, reads the returned instruction word in the same cycle, and executes it. The subset covers byte-wide immediate loads into either half of a register, a jump through a register, a two-register store that walks a pointer downward, an unsigned compare followed by carry branches, logical and arithmetic right shifts, and a counted loop driven by a dedicated loop counter.

A small state machine sequences the core. In `RUN` it decodes and retires one instruction per cycle. A paired store leaves `RUN` for `PUSH_HI`, where the odd register of the pair goes to the address in the pointer register and the pointer drops by one. It then passes to `PUSH_LO`, where the even register goes to the new pointer address and the pointer drops again, and returns to `RUN`. The transitions are: RUN to PUSH_HI on a paired store, RUN to RUN otherwise, PUSH_HI to PUSH_LO always, and PUSH_LO to RUN always. The data port only writes, one word per cycle.

Top module: `dsp16_core`

## Requirements
- R1: While reset is high the program counter, all sixteen 16-bit registers, the carry flag and the loop counter are cleared, and the data write strobe is low.
- R2: A word 0x2Rii replaces the low byte of register R with ii and keeps the high byte.
- R3: A word 0x3Rii replaces the high byte of register R with ii and keeps the low byte.
- R4: The word 0xBB0R loads the program counter with the contents of register R, so the next fetch is from that word address.
- R5: A word 0x5Pq? (pointer P in bits 11:8, pair number q in bits 7:5) first writes register 2q+1 to the address held in P and decrements P. In the following cycle it writes register 2q to the address now in P and decrements P again. The program counter then advances by one.
- R6: A word 0x6AB? compares register A with register B and sets carry to 1 when A is unsigned greater than or equal to B, and to 0 otherwise.
- R7: A word 0x70oo branches when carry is 0 and 0x71oo branches when carry is 1. The target is the branch address plus one plus the sign-extended offset oo.
- R8: A word 0x8Rkm shifts register R right by k (0 to 15) places. It fills zeros when bit 0 of m is 0 and copies of bit 15 when that bit is 1.
- R9: The word 0x9R00 loads the loop counter from register R, and 0x9R01 copies the loop counter into register R.
- R10: A word 0xA?oo decrements the loop counter and branches as in R7 when the decremented value is not zero, and otherwise falls through.
- R11: Every other word, including 0x72oo to 0x7Foo, 0x9Rxx with xx above 01, and 0xBxxx not of the form 0xBB0R, changes no state except that the program counter advances by one.
- R12: Every instruction except the paired store retires in one cycle with the write strobe low. The paired store takes three cycles and holds the program counter until its last cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Word address of the instruction to fetch (the program counter) |
| imem_rdata | input | 16 | Instruction word at imem_addr, valid in the same cycle |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | 16 | Data memory word address, meaningful when dmem_we is high |
| dmem_wdata | output | 16 | Data memory write value, meaningful when dmem_we is high |

## Verification
The assertions assume that the instruction memory answers combinationally, so that imem_rdata belongs to the current imem_addr, and that the memory does not change while a paired store is in progress. They make no assumption about which words are fetched, because every 16-bit word is a legal instruction. The bench keeps to these conditions by serving fetches from an array that it fills only while reset is high, and by letting random programs branch and jump anywhere with the address folded into that array. A reference model in the bench steps through the same words and predicts each fetch address and every store.

// File: rtl/dsp16_pkg.sv
package dsp16_pkg;

    localparam int WORD_W    = 16;
    localparam int NUM_REGS  = 16;
    localparam int REG_IDX_W = $clog2(NUM_REGS);
    localparam int IMM_W     = 8;
    localparam int SHAMT_W   = $clog2(WORD_W);

    // major opcode nibble (bits 15:12)
    localparam logic [3:0] MAJ_MOVL  = 4'h2;
    localparam logic [3:0] MAJ_MOVH  = 4'h3;
    localparam logic [3:0] MAJ_PUSH  = 4'h5;
    localparam logic [3:0] MAJ_CMP   = 4'h6;
    localparam logic [3:0] MAJ_BR    = 4'h7;
    localparam logic [3:0] MAJ_SHIFT = 4'h8;
    localparam logic [3:0] MAJ_CTR   = 4'h9;
    localparam logic [3:0] MAJ_LOOP  = 4'hA;
    localparam logic [3:0] MAJ_JMP   = 4'hB;
    localparam logic [7:0] JMP_TAG   = 8'hB0;

    typedef enum logic [3:0] {
        OP_NOP,
        OP_MOVL,
        OP_MOVH,
        OP_JMP,
        OP_PUSH,
        OP_CMP,
        OP_BCC,
        OP_BCS,
        OP_SHIFT,
        OP_TOCTR,
        OP_FROMCTR,
        OP_LOOP
    } op_e;

    typedef enum logic [1:0] {
        S_RUN     = 2'd0,
        S_PUSH_HI = 2'd1,
        S_PUSH_LO = 2'd2
    } state_e;

    typedef struct packed {
        op_e                  op;
        logic [REG_IDX_W-1:0] fa;   // bits 11:8
        logic [REG_IDX_W-1:0] fb;   // bits 7:4
        logic [REG_IDX_W-1:0] fc;   // bits 3:0
        logic [IMM_W-1:0]     imm;  // bits 7:0
    } dec_t;

endpackage

// File: rtl/dsp16_decode.sv
module dsp16_decode
    import dsp16_pkg::*;
(
    input  logic [WORD_W-1:0] insn,
    output dec_t              dec
);

    always_comb begin
        dec.fa  = insn[11:8];
        dec.fb  = insn[7:4];
        dec.fc  = insn[3:0];
        dec.imm = insn[7:0];
        dec.op  = OP_NOP;
        unique case (insn[15:12])
            MAJ_MOVL:  dec.op = OP_MOVL;
            MAJ_MOVH:  dec.op = OP_MOVH;
            MAJ_PUSH:  dec.op = OP_PUSH;
            MAJ_CMP:   dec.op = OP_CMP;
            MAJ_SHIFT: dec.op = OP_SHIFT;
            MAJ_LOOP:  dec.op = OP_LOOP;
            MAJ_BR: begin
                if (insn[11:8] == 4'h0)      dec.op = OP_BCC;
                else if (insn[11:8] == 4'h1) dec.op = OP_BCS;
            end
            MAJ_CTR: begin
                if (insn[7:0] == 8'h00)      dec.op = OP_TOCTR;
                else if (insn[7:0] == 8'h01) dec.op = OP_FROMCTR;
            end
            MAJ_JMP: begin
                if (insn[11:4] == JMP_TAG)   dec.op = OP_JMP;
            end
            default: dec.op = OP_NOP;
        endcase
    end

endmodule

// File: rtl/dsp16_shifter.sv
module dsp16_shifter #(
    parameter int W    = 16,
    parameter int SH_W = $clog2(W)
) (
    input  logic [W-1:0]    din,
    input  logic [SH_W-1:0] amt,
    input  logic            arith,
    output logic [W-1:0]    dout
);

    logic            fill;
    logic [W-1:0]    stage [SH_W+1];

    assign fill     = arith & din[W-1];
    assign stage[0] = din;

    for (genvar k = 0; k < SH_W; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign stage[k+1] = amt[k] ? {{SH{fill}}, stage[k][W-1:SH]} : stage[k];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/dsp16_regfile.sv
module dsp16_regfile #(
    parameter int W  = 16,
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [IW-1:0] ra_idx,
    output logic [W-1:0]  ra_data,
    input  logic [IW-1:0] rb_idx,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [IW-1:0] w_idx,
    input  logic [W-1:0]  w_data
);

    logic [W-1:0] regs [N];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) begin
                regs[i] <= '0;
            end
        end else if (we) begin
            regs[w_idx] <= w_data;
        end
    end

    assign ra_data = regs[ra_idx];
    assign rb_data = regs[rb_idx];

    // R1: every register reads zero in the first cycle after reset
    p_regs_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ra_data == '0 && rb_data == '0));

endmodule

// File: rtl/dsp16_core.sv
module dsp16_core
    import dsp16_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    output logic [WORD_W-1:0] imem_addr,
    input  logic [WORD_W-1:0] imem_rdata,
    output logic              dmem_we,
    output logic [WORD_W-1:0] dmem_addr,
    output logic [WORD_W-1:0] dmem_wdata
);

    state_e                state_q, state_d;
    logic [WORD_W-1:0]     pc_q, pc_d;
    logic [WORD_W-1:0]     ir_q;
    logic [WORD_W-1:0]     insn;
    logic                  carry_q, carry_d;
    logic [WORD_W-1:0]     ctr_q, ctr_d;
    dec_t                  dec;

    logic [REG_IDX_W-1:0]  ra_idx, rb_idx, rf_widx;
    logic [WORD_W-1:0]     ra_data, rb_data, rf_wdata;
    logic                  rf_we;
    logic [WORD_W-1:0]     shift_out;
    logic [WORD_W-1:0]     pc_inc, br_tgt, ctr_dec;

    // the fetched word is used while running; a paired store replays the held word
    assign insn      = (state_q == S_RUN) ? imem_rdata : ir_q;
    assign imem_addr = pc_q;
    assign pc_inc    = pc_q + 1'b1;
    assign br_tgt    = pc_inc + {{(WORD_W-IMM_W){dec.imm[IMM_W-1]}}, dec.imm};
    assign ctr_dec   = ctr_q - 1'b1;

    dsp16_decode u_decode (
        .insn (insn),
        .dec  (dec)
    );

    dsp16_regfile #(
        .W (WORD_W),
        .N (NUM_REGS)
    ) u_regfile (
        .clk     (clk),
        .rst     (rst),
        .ra_idx  (ra_idx),
        .ra_data (ra_data),
        .rb_idx  (rb_idx),
        .rb_data (rb_data),
        .we      (rf_we),
        .w_idx   (rf_widx),
        .w_data  (rf_wdata)
    );

    dsp16_shifter #(
        .W (WORD_W)
    ) u_shifter (
        .din   (ra_data),
        .amt   (dec.fb[SHAMT_W-1:0]),
        .arith (dec.fc[0]),
        .dout  (shift_out)
    );

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= S_RUN;
        else     state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_RUN:     state_d = (dec.op == OP_PUSH) ? S_PUSH_HI : S_RUN;
            S_PUSH_HI: state_d = S_PUSH_LO;
            S_PUSH_LO: state_d = S_RUN;
            default:   state_d = S_RUN;
        endcase
    end

    // register read selection, kept apart from the data path that consumes it
    always_comb begin
        ra_idx = dec.fa;
        rb_idx = dec.fb;
        unique case (state_q)
            S_RUN:     if (dec.op == OP_JMP) ra_idx = dec.fc;
            S_PUSH_HI: rb_idx = {dec.fb[REG_IDX_W-1:1], 1'b1};
            S_PUSH_LO: rb_idx = {dec.fb[REG_IDX_W-1:1], 1'b0};
            default:   ra_idx = dec.fa;
        endcase
    end

    // outputs and data path
    always_comb begin
        pc_d       = pc_q;
        carry_d    = carry_q;
        ctr_d      = ctr_q;
        rf_we      = 1'b0;
        rf_widx    = dec.fa;
        rf_wdata   = ra_data;
        dmem_we    = 1'b0;
        dmem_addr  = ra_data;
        dmem_wdata = rb_data;
        unique case (state_q)
            S_RUN: begin
                pc_d = pc_inc;
                unique case (dec.op)
                    OP_MOVL: begin
                        rf_we    = 1'b1;
                        rf_wdata = {ra_data[WORD_W-1:IMM_W], dec.imm};
                    end
                    OP_MOVH: begin
                        rf_we    = 1'b1;
                        rf_wdata = {dec.imm, ra_data[IMM_W-1:0]};
                    end
                    OP_JMP:     pc_d = ra_data;
                    OP_PUSH:    pc_d = pc_q;
                    OP_CMP:     carry_d = (ra_data >= rb_data);
                    OP_BCC:     if (!carry_q) pc_d = br_tgt;
                    OP_BCS:     if (carry_q)  pc_d = br_tgt;
                    OP_SHIFT: begin
                        rf_we    = 1'b1;
                        rf_wdata = shift_out;
                    end
                    OP_TOCTR:   ctr_d = ra_data;
                    OP_FROMCTR: begin
                        rf_we    = 1'b1;
                        rf_wdata = ctr_q;
                    end
                    OP_LOOP: begin
                        ctr_d = ctr_dec;
                        if (ctr_dec != '0) pc_d = br_tgt;
                    end
                    default: pc_d = pc_inc;
                endcase
            end
            S_PUSH_HI: begin
                dmem_we  = 1'b1;
                rf_we    = 1'b1;
                rf_wdata = ra_data - 1'b1;
            end
            S_PUSH_LO: begin
                dmem_we  = 1'b1;
                rf_we    = 1'b1;
                rf_wdata = ra_data - 1'b1;
                pc_d     = pc_inc;
            end
            default: pc_d = pc_q;
        endcase
    end

    // architectural state
    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q    <= '0;
            carry_q <= 1'b0;
            ctr_q   <= '0;
            ir_q    <= '0;
        end else begin
            pc_q    <= pc_d;
            carry_q <= carry_d;
            ctr_q   <= ctr_d;
            if (state_q == S_RUN) ir_q <= imem_rdata;
        end
    end

    // R1: first fetch after reset is word 0
    p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (imem_addr == '0 && !dmem_we));

    // R4: register jump lands on the register value
    p_jump_r4: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && dec.op == OP_JMP) |=> (pc_q == $past(ra_data)));

    // R5: second store address sits one below the first
    p_push_step_r5: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PUSH_LO) |-> (dmem_addr == $past(dmem_addr) - 16'd1));

    // R12: program counter holds through the first store cycle
    p_push_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_PUSH_HI) |=> (state_q == S_PUSH_LO && $stable(pc_q)));

    // R6: carry reflects the unsigned comparison
    p_cmp_carry_r6: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && dec.op == OP_CMP) |=> (carry_q == ($past(ra_data) >= $past(rb_data))));

    // R10: loop falls through when the counter reaches zero
    p_loop_exit_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && dec.op == OP_LOOP && ctr_q == 16'd1)
        |=> (pc_q == $past(pc_q) + 16'd1 && ctr_q == '0));

    // R11: unlisted words only advance the program counter
    p_nop_advance_r11: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_RUN && dec.op == OP_NOP)
        |=> (pc_q == $past(pc_q) + 16'd1 && $stable(carry_q) && $stable(ctr_q)));

endmodule

// File: tb/dsp16_core_tb_top.sv
`timescale 1ns/1ps
module dsp16_core_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata;
    logic        dmem_we;
    logic [15:0] imem [256];

    assign imem_rdata = imem[imem_addr[7:0]];

    dsp16_core dut_i (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_we    (dmem_we),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata)
    );

    always #2.5 clk = ~clk;

    int    checks   = 0;
    int    failures = 0;
    int    cyc      = 0;
    bit    done     = 1'b0;
    string last_tag = "R1";

    // reference model state
    logic [15:0] m_r [16];
    logic [15:0] m_pc, m_ctr;
    logic        m_c;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL R12 watchdog actual=%0d expected=150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] sx(input logic [7:0] v);
        return {{8{v[7]}}, v};
    endfunction

    function automatic string tag_of(input logic [15:0] w);
        case (w[15:12])
            4'h2: return "R2";
            4'h3: return "R3";
            4'h5: return "R5";
            4'h6: return "R6";
            4'h7: return (w[11:8] <= 4'h1) ? "R7" : "R11";
            4'h8: return "R8";
            4'h9: return (w[7:0] <= 8'h01) ? "R9" : "R11";
            4'hA: return "R10";
            4'hB: return (w[11:4] == 8'hB0) ? "R4" : "R11";
            default: return "R11";
        endcase
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 16; i++) m_r[i] = 16'h0000;
        m_pc  = 16'h0000;
        m_ctr = 16'h0000;
        m_c   = 1'b0;
    endtask

    task automatic m_exec(input logic [15:0] w);
        logic [3:0]  a;
        logic [3:0]  b;
        logic [7:0]  im;
        logic [15:0] nxt;
        a   = w[11:8];
        b   = w[7:4];
        im  = w[7:0];
        nxt = m_pc + 16'd1;
        case (w[15:12])
            4'h2: m_r[a] = {m_r[a][15:8], im};
            4'h3: m_r[a] = {im, m_r[a][7:0]};
            4'h6: m_c = (m_r[a] >= m_r[b]);
            4'h7: begin
                if (a == 4'h0 && !m_c) nxt = m_pc + 16'd1 + sx(im);
                if (a == 4'h1 && m_c)  nxt = m_pc + 16'd1 + sx(im);
            end
            4'h8: begin
                if (w[0]) m_r[a] = 16'($signed(m_r[a]) >>> b);
                else      m_r[a] = m_r[a] >> b;
            end
            4'h9: begin
                if (im == 8'h00)      m_ctr = m_r[a];
                else if (im == 8'h01) m_r[a] = m_ctr;
            end
            4'hA: begin
                m_ctr = m_ctr - 16'd1;
                if (m_ctr != 16'd0) nxt = m_pc + 16'd1 + sx(im);
            end
            4'hB: if (w[11:4] == 8'hB0) nxt = m_r[w[3:0]];
            default: ;
        endcase
        m_pc = nxt;
    endtask

    task automatic clear_imem();
        for (int i = 0; i < 256; i++) imem[i] = 16'h0000;
    endtask

    task automatic start_prog();
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        @(negedge clk);
        chk("R1", "pc under reset", imem_addr, 16'h0000);
        chk("R1", "write strobe under reset", {15'd0, dmem_we}, 16'h0000);
        m_reset();
        last_tag = "R1";
        rst = 1'b0;
    endtask

    task automatic run(input int steps);
        for (int s = 0; s < steps; s++) begin
            logic [15:0] w;
            logic [3:0]  p, od, ev;
            chk(last_tag, "fetch address", imem_addr, m_pc);
            chk("R12", "write strobe in issue cycle", {15'd0, dmem_we}, 16'h0000);
            w = imem[m_pc[7:0]];
            if (w[15:12] == 4'h5) begin
                p  = w[11:8];
                od = {w[7:5], 1'b1};
                ev = {w[7:5], 1'b0};
                @(negedge clk);
                chk("R12", "pc held in first store cycle", imem_addr, m_pc);
                chk("R5", "first store strobe", {15'd0, dmem_we}, 16'h0001);
                chk("R5", "first store address", dmem_addr, m_r[p]);
                chk("R5", "first store data (odd reg)", dmem_wdata, m_r[od]);
                m_r[p] = m_r[p] - 16'd1;
                @(negedge clk);
                chk("R5", "second store strobe", {15'd0, dmem_we}, 16'h0001);
                chk("R5", "second store address", dmem_addr, m_r[p]);
                chk("R5", "second store data (even reg)", dmem_wdata, m_r[ev]);
                m_r[p] = m_r[p] - 16'd1;
                m_pc = m_pc + 16'd1;
                last_tag = "R5";
                @(negedge clk);
            end else begin
                m_exec(w);
                last_tag = tag_of(w);
                @(negedge clk);
            end
        end
    endtask

    function automatic logic [15:0] rand_word();
        int unsigned k;
        logic [3:0]  r, q;
        logic [7:0]  im;
        k  = $urandom % 12;
        r  = 4'($urandom);
        q  = 4'($urandom);
        im = 8'($urandom);
        case (k)
            0:  return {4'h2, r, im};
            1:  return {4'h3, r, im};
            2:  return {12'hBB0, r};
            3:  return {4'h5, r, q[2:0], 5'($urandom)};
            4:  return {4'h6, r, q, 4'($urandom)};
            5:  return {4'h7, 3'b000, 1'($urandom), im};
            6:  return {4'h8, r, q, 4'($urandom)};
            7:  return {4'h9, r, 8'h00};
            8:  return {4'h9, r, 8'h01};
            9:  return {4'hA, 4'($urandom), im};
            default: return 16'($urandom);
        endcase
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));

        // R1: reset contents observed through stores, carry and counter
        clear_imem();
        imem[0] = 16'h9101; imem[1] = 16'h7002; imem[2] = 16'h2155; imem[3] = 16'h2155;
        imem[4] = 16'h5C00; imem[5] = 16'h5C20; imem[6] = 16'h5C40; imem[7] = 16'h5C60;
        imem[8] = 16'h5CA0; imem[9] = 16'h5CE0;
        start_prog();
        run(14);

        // R2 R3 R8: byte loads and both shift kinds, seen through stores
        clear_imem();
        imem[0]  = 16'h2134; imem[1]  = 16'h3182; imem[2]  = 16'h2C00; imem[3]  = 16'h3C01;
        imem[4]  = 16'h5C00; imem[5]  = 16'h8141; imem[6]  = 16'h5C00; imem[7]  = 16'h2234;
        imem[8]  = 16'h3282; imem[9]  = 16'h82F0; imem[10] = 16'h5C20; imem[11] = 16'h2334;
        imem[12] = 16'h3382; imem[13] = 16'h83F1; imem[14] = 16'h8300; imem[15] = 16'h5C20;
        start_prog();
        run(20);

        // R6 R7: less, greater, equal compares with both branch senses
        clear_imem();
        imem[0]  = 16'h2105; imem[1]  = 16'h2207; imem[2]  = 16'h6120; imem[3]  = 16'h7105;
        imem[4]  = 16'h7001; imem[5]  = 16'h2F99; imem[6]  = 16'h6210; imem[7]  = 16'h7101;
        imem[8]  = 16'h2F88; imem[9]  = 16'h6110; imem[10] = 16'h7001; imem[11] = 16'h70FF;
        imem[12] = 16'h7200; imem[13] = 16'h5CE0;
        start_prog();
        run(18);

        // R9 R10: counted loop of three, exit at zero, wrap from zero
        clear_imem();
        imem[0] = 16'h2303; imem[1] = 16'h9300; imem[2] = 16'h2401; imem[3] = 16'hA0FE;
        imem[4] = 16'h9501; imem[5] = 16'h5C40; imem[6] = 16'hA001; imem[7] = 16'h2FFF;
        imem[8] = 16'h9601; imem[9] = 16'h5C60;
        start_prog();
        run(20);

        // R4 R11: register jump, then words outside the subset
        clear_imem();
        imem[0]    = 16'h2610; imem[1]    = 16'hBB06;
        imem[8'h10] = 16'hBB16; imem[8'h11] = 16'h0000; imem[8'h12] = 16'hF123;
        imem[8'h13] = 16'h4ABC; imem[8'h14] = 16'h9205; imem[8'h15] = 16'h7255;
        imem[8'h16] = 16'hC000; imem[8'h17] = 16'h1FFF; imem[8'h18] = 16'hBA06;
        imem[8'h19] = 16'h2C80; imem[8'h1A] = 16'h5C00;
        start_prog();
        run(14);

        // constrained random programs over all instruction classes
        for (int n = 0; n < 30; n++) begin
            for (int i = 0; i < 256; i++) imem[i] = rand_word();
            start_prog();
            run(200);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule